// File: doc/BRIEF.md
# PCIe Host-Bridge PHY Register Bank

This block holds the control and status words of a PCIe host-bridge PHY behind a plain register bus. The bus presents a byte address, a write enable with four byte strobes and a read enable. Each access targets one 32-bit word, chosen by the byte address with its two low bits dropped. The bank holds 64 words. Reset first clears every word, then writes fixed identification, class-code, data-link and link-status words. Ordinary words keep whatever lanes are written to them.

One word acts as a write-protect latch. It never stores the data written to it. Instead it records a single flag that says whether the low byte of the latest accepted write matched the unlock key 0xA8. That flag also drives the `unlocked` output, so that neighbouring logic can gate its own writes on it. Reads are registered and return data one cycle after the request.

Top module: `phy_regbank`

## Requirements
- R1: After reset, the word at byte offset 0x00 reads {16'h1150, VENDOR_ID}, offset 0x04 reads 0x06040006, offset 0x10 reads 0xD7040022 and offset 0xC0 reads 0x00000020 (bit 5 set: link up).
- R2: After reset, every other word reads zero, and `unlocked` is low.
- R3: A write with all four strobes set to any word other than offset 0x7C stores the data unchanged, and a later read returns it.
- R4: Strobe bit n enables byte lane n (bits 8n+7:8n), little-endian. Lanes whose strobe is low keep their previous contents.
- R5: A write to offset 0x7C with strobe bit 0 set and data bits [7:0] equal to 0xA8 makes that word read 0x00000001 and raises `unlocked` on the next cycle. Bits [31:8] of the data are ignored.
- R6: A write to offset 0x7C with strobe bit 0 set and any other value in bits [7:0] makes that word read 0x00000000 and lowers `unlocked`.
- R7: A write to offset 0x7C with strobe bit 0 clear has no effect on that word or on `unlocked`.
- R8: Read data appears on `bus_rdata` in the cycle after the cycle in which `bus_re` is sampled high, and it holds while `bus_re` is low. If a read and a write hit the same word in the same cycle, the read returns the old contents.
- R9: Address bits [1:0] are ignored. Any byte address inside a word selects that word.
- R10: `unlocked` is high exactly when the word at offset 0x7C holds 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_addr | input | 8 | Byte address of the access |
| bus_we | input | 1 | Write enable |
| bus_be | input | 4 | Byte-lane strobes for writes |
| bus_wdata | input | 32 | Write data |
| bus_re | input | 1 | Read enable |
| bus_rdata | output | 32 | Registered read data |
| unlocked | output | 1 | High while the protect latch holds the key flag |

## Verification
A read and a write can fall in the same cycle on the same word. The bench provokes this by raising `bus_re` and `bus_we` together on an ordinary word and on the protect word. It then requires the returned data to be the value held before the write, and a follow-up read to show the new value. Strobe patterns are combined with the same collisions, which catches a bank that forwards write data into the read path or that updates masked lanes.

// File: rtl/phy_regbank.sv
module phy_regbank #(
  parameter int          ADDR_W     = 8,
  parameter int          DATA_W     = 32,
  parameter logic [15:0] VENDOR_ID  = 16'h5A17,
  parameter logic [7:0]  UNLOCK_KEY = 8'hA8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [ADDR_W-1:0]   bus_addr,
  input  logic                bus_we,
  input  logic [DATA_W/8-1:0] bus_be,
  input  logic [DATA_W-1:0]   bus_wdata,
  input  logic                bus_re,
  output logic [DATA_W-1:0]   bus_rdata,
  output logic                unlocked
);

  localparam int IDX_W    = ADDR_W - 2;
  localparam int NWORDS   = 2 ** IDX_W;
  localparam int LANES    = DATA_W / 8;
  localparam int ID_IDX   = 'h00 >> 2;
  localparam int CLS_IDX  = 'h04 >> 2;
  localparam int DLL_IDX  = 'h10 >> 2;
  localparam int PROT_IDX = 'h7C >> 2;
  localparam int LINK_IDX = 'hC0 >> 2;

  logic [DATA_W-1:0] regs [NWORDS];
  logic [IDX_W-1:0]  idx;
  logic              key_hit;
  logic              unused_addr_lsb;

  assign idx             = bus_addr[ADDR_W-1:2];
  assign key_hit         = (bus_wdata[7:0] == UNLOCK_KEY);
  assign unused_addr_lsb = ^bus_addr[1:0];

  function automatic logic [DATA_W-1:0] rst_word(input int i);
    case (i)
      ID_IDX:   rst_word = DATA_W'({16'h1150, VENDOR_ID});
      CLS_IDX:  rst_word = DATA_W'(32'h0604_0006);
      DLL_IDX:  rst_word = DATA_W'(32'hD704_0022);
      LINK_IDX: rst_word = DATA_W'(32'h0000_0020);
      default:  rst_word = '0;
    endcase
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NWORDS; i++) regs[i] <= rst_word(i);
    end else if (bus_we) begin
      if (idx == IDX_W'(PROT_IDX)) begin
        if (bus_be[0]) regs[PROT_IDX] <= {{(DATA_W-1){1'b0}}, key_hit};
      end else begin
        for (int j = 0; j < LANES; j++)
          if (bus_be[j]) regs[idx][j*8 +: 8] <= bus_wdata[j*8 +: 8];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      bus_rdata <= '0;
    else if (bus_re) bus_rdata <= regs[idx];
  end

  assign unlocked = regs[PROT_IDX][0];

endmodule

// File: rtl/phy_regbank_chk.sv
module phy_regbank_chk #(
  parameter int          ADDR_W     = 8,
  parameter int          DATA_W     = 32,
  parameter logic [7:0]  UNLOCK_KEY = 8'hA8
) (
  input logic                clk,
  input logic                rst_n,
  input logic [ADDR_W-1:0]   bus_addr,
  input logic                bus_we,
  input logic [DATA_W/8-1:0] bus_be,
  input logic [DATA_W-1:0]   bus_wdata,
  input logic                bus_re,
  input logic [DATA_W-1:0]   bus_rdata,
  input logic                unlocked
);
  logic prot_hit;
  assign prot_hit = bus_addr[ADDR_W-1:2] == (ADDR_W-2)'('h7C >> 2);

  assert_key_sets_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_be[0] && prot_hit && bus_wdata[7:0] == UNLOCK_KEY) |=> unlocked);

  assert_bad_key_clears_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_be[0] && prot_hit && bus_wdata[7:0] != UNLOCK_KEY) |=> !unlocked);

  assert_lane0_gate_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_we && bus_be[0] && prot_hit) |=> $stable(unlocked));

  assert_rdata_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_re |=> $stable(bus_rdata));

  assert_prot_read_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_re && prot_hit) |=> bus_rdata == {{(DATA_W-1){1'b0}}, $past(unlocked)});
endmodule

bind phy_regbank phy_regbank_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .UNLOCK_KEY(UNLOCK_KEY)
) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
  .bus_be(bus_be), .bus_wdata(bus_wdata), .bus_re(bus_re),
  .bus_rdata(bus_rdata), .unlocked(unlocked)
);

// File: tb/phy_regbank_bench.sv
module phy_regbank_bench;
  logic        clk = 0;
  logic        rst_n = 0;
  logic [7:0]  bus_addr = 0;
  logic        bus_we = 0;
  logic [3:0]  bus_be = 0;
  logic [31:0] bus_wdata = 0;
  logic        bus_re = 0;
  logic [31:0] bus_rdata;
  logic        unlocked;
  int checks = 0;
  int failures = 0;
  bit done = 0;

  always #5 clk = ~clk;

  phy_regbank u_phy_regbank (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_be(bus_be), .bus_wdata(bus_wdata), .bus_re(bus_re),
    .bus_rdata(bus_rdata), .unlocked(unlocked)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [3:0] be, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_be = be; bus_wdata = d; bus_we = 1;
    @(negedge clk);
    bus_we = 0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_re = 1;
    @(negedge clk);
    bus_re = 0;
    d = bus_rdata;
  endtask

  task automatic t_reset;
    logic [31:0] d;
    rd(8'h00, d); check("R1 id", d, 32'h1150_5A17);
    rd(8'h04, d); check("R1 class", d, 32'h0604_0006);
    rd(8'h10, d); check("R1 datalink", d, 32'hD704_0022);
    rd(8'hC0, d); check("R1 link", d, 32'h0000_0020);
    rd(8'h08, d); check("R2 zero 08", d, 0);
    rd(8'hFC, d); check("R2 zero FC", d, 0);
    rd(8'h7C, d); check("R2 protect", d, 0);
    check("R2 unlocked", {31'b0, unlocked}, 0);
  endtask

  task automatic t_full_write;
    logic [31:0] d;
    wr(8'h20, 4'hF, 32'hCAFE_F00D); rd(8'h20, d); check("R3 word 20", d, 32'hCAFE_F00D);
    wr(8'h00, 4'hF, 32'h1234_5678); rd(8'h00, d); check("R3 id overwrite", d, 32'h1234_5678);
  endtask

  task automatic t_strobes;
    logic [31:0] d;
    wr(8'h30, 4'hF, 32'h1122_3344);
    wr(8'h30, 4'b0101, 32'hAABB_CCDD); rd(8'h30, d); check("R4 lanes 0,2", d, 32'h11BB_33DD);
    wr(8'h30, 4'b1000, 32'hEE00_0000); rd(8'h30, d); check("R4 lane 3", d, 32'hEEBB_33DD);
    wr(8'h30, 4'b0000, 32'h0); rd(8'h30, d); check("R4 no lanes", d, 32'hEEBB_33DD);
  endtask

  task automatic t_protect;
    logic [31:0] d;
    wr(8'h7C, 4'b0001, 32'h0000_00A8); rd(8'h7C, d); check("R5 key", d, 1);
    check("R10 unlocked high", {31'b0, unlocked}, 1);
    wr(8'h7C, 4'h1, 32'h0000_00A9); rd(8'h7C, d); check("R6 near miss", d, 0);
    check("R10 unlocked low", {31'b0, unlocked}, 0);
    wr(8'h7C, 4'hF, 32'hFFFF_FFA8); rd(8'h7C, d); check("R5 upper ignored", d, 1);
    wr(8'h7C, 4'b1110, 32'h0000_0000); rd(8'h7C, d); check("R7 lane0 off", d, 1);
    check("R7 unlocked kept", {31'b0, unlocked}, 1);
    wr(8'h7C, 4'h1, 32'hA800_0000); rd(8'h7C, d); check("R6 key in wrong byte", d, 0);
    wr(8'h7C, 4'b0010, 32'h0000_A8A8); rd(8'h7C, d); check("R7 stays clear", d, 0);
  endtask

  task automatic t_collide;
    logic [31:0] d;
    wr(8'h40, 4'hF, 32'h0000_1111);
    @(negedge clk);
    bus_addr = 8'h40; bus_be = 4'b0011; bus_wdata = 32'h5555_2222; bus_we = 1; bus_re = 1;
    @(negedge clk);
    bus_we = 0; bus_re = 0;
    check("R8 read old", bus_rdata, 32'h0000_1111);
    @(negedge clk);
    check("R8 rdata held", bus_rdata, 32'h0000_1111);
    rd(8'h40, d); check("R8 read new", d, 32'h0000_2222);
    @(negedge clk);
    bus_addr = 8'h7C; bus_be = 4'h1; bus_wdata = 32'hA8; bus_we = 1; bus_re = 1;
    @(negedge clk);
    bus_we = 0; bus_re = 0;
    check("R8 protect old", bus_rdata, 0);
    rd(8'h7C, d); check("R8 protect new", d, 1);
  endtask

  task automatic t_addr_lsb;
    logic [31:0] d;
    wr(8'h53, 4'hF, 32'h0BAD_BEEF); rd(8'h50, d); check("R9 write via 53", d, 32'h0BAD_BEEF);
    rd(8'h52, d); check("R9 read via 52", d, 32'h0BAD_BEEF);
    wr(8'h7E, 4'h1, 32'h0); rd(8'h7D, d); check("R9 protect via 7E", d, 0);
    check("R10 follows", {31'b0, unlocked}, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset();
    t_full_write();
    t_strobes();
    t_protect();
    t_collide();
    t_addr_lsb();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule